// File: doc/BRIEF.md
# LCD Controller Interrupt Aggregator

This block gathers the event strobes of a display controller into two status registers and drives a single level-sensitive interrupt. Each DMA channel can report start of frame, end of frame, branch taken and bus error. The start-of-frame and end-of-frame strobes count only when the channel's current descriptor command word enables them. Controller-wide strobes cover last frame done, AC-bias count, input underrun on channels 0 and 1, output underrun, read status and command interrupt. A quick-disable flag is raised when software turns the controller enable off.

Software clears status bits by writing ones to them and masks sources through two mask registers, where a set bit disables a source. The first unmasked channel event that arrives while no interrupt is pending loads that channel's frame ID into an ID register. Any later such event that arrives while the interrupt is already pending, or that arrives together with another one in the same cycle, sets a secondary-interrupt flag instead. The register port has one write and one read channel. Read data is registered.

Top module: `lcd_irq_agg`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A start-of-frame strobe is recorded only when bit 22 of the channel's command word is 1. An end-of-frame strobe is recorded only when bit 21 is 1. Channel 0 records them in primary status bits 1 and 8. Channel ch (1 to 6) records them in secondary status bits ch-1 and ch+7.
- R3: A branch strobe sets primary bit 9 for channel 0 and secondary bit ch+15 for channel ch of 1 to 6.
- R4: A bus-error strobe sets primary bit 2 whatever the masks hold, and writes the channel number into primary bits 30:28. When several channels report in one cycle, the lowest channel number is written.
- R5: `irq` is 1 exactly when a primary status bit in 12:0 is 1 while the same bit of mask 0 is 0, or when a secondary status bit is 1 while the same bit of mask 1 is 0. `irq` is registered and follows any status or mask change one cycle later.
- R6: A qualifying event is an unmasked start-of-frame, end-of-frame or branch event, or any bus error. If qualifying events arrive while no interrupt is pending, the ID register loads the frame ID of the lowest-numbered requesting channel. A masked event does not load it.
- R7: Primary bit 10 is set, and the ID register keeps its value, when a qualifying event arrives while the interrupt is pending. Bit 10 is also set when two or more qualifying events arrive in one cycle. In that case the ID is still loaded.
- R8: A write to primary status clears each bit of 11:0 that is 1 in the written value. Bit 12 cannot be cleared. If written bit 2 is 1, bits 30:28 are cleared too.
- R9: A write to secondary status clears only bits that are 1 in both the written value and 0x3e3f3f. The channel-1 branch bit 16, for example, stays set.
- R10: A control write with bit 0 = 0 while the stored enable (bit 0) is 1 sets primary bit 7. Other control writes leave bit 7 unchanged.
- R11: If a clearing write and a new event hit the same status bit in one cycle, the bit stays 1.
- R12: The controller-wide strobes set primary bits as follows: last frame done bit 0, AC-bias bit 3, underrun 0 bit 4, underrun 1 bit 5, output underrun bit 6, read status bit 11, command interrupt bit 12.
- R13: The register addresses are 0 control, 1 primary status, 2 secondary status, 3 mask 0, 4 mask 1 and 5 ID. Other addresses read 0. Mask 0 keeps bits 12:0 and mask 1 keeps bits under 0x3f3f3f3f. `rd_data` shows the register addressed one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 32 | Registered read data |
| sof_stb | input | NCH | Start-of-frame strobe per channel |
| eof_stb | input | NCH | End-of-frame strobe per channel |
| bs_stb | input | NCH | Branch-taken strobe per channel |
| ber_stb | input | NCH | Bus-error strobe per channel |
| ch_cmd | input | NCH*32 | Descriptor command word per channel |
| ch_fid | input | NCH*ID_W | Frame ID per channel |
| iu_stb | input | 2 | Input underrun strobes, channels 0 and 1 |
| ldd_stb | input | 1 | Last frame done strobe |
| abc_stb | input | 1 | AC-bias count strobe |
| ou_stb | input | 1 | Output underrun strobe |
| rdst_stb | input | 1 | Read status strobe |
| cmdi_stb | input | 1 | Command interrupt strobe |
| irq | output | 1 | Registered interrupt level |

## Verification
Status bits, the ID register and the secondary-interrupt flag take their new value at the clock edge where a strobe or write is sampled. `irq` changes one edge after that, and `rd_data` one edge after the read address is sampled. The bench drives every stimulus at a falling edge and holds it for one cycle. It reads registers by setting the address at one falling edge and sampling at the next. It tests `irq` at both the first and second falling edge after a change, so that the exact one-cycle lag is confirmed. Simultaneous cases, such as a clear colliding with an event or two channels reporting at once, are driven at the same falling edge so they meet at a single clock edge.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  localparam int REG_W = 32;

  // register addresses
  localparam int A_CTRL  = 0;
  localparam int A_STAT0 = 1;
  localparam int A_STAT1 = 2;
  localparam int A_MASK0 = 3;
  localparam int A_MASK1 = 4;
  localparam int A_ID    = 5;

  // primary status bit positions
  localparam int B_LDD  = 0;
  localparam int B_SOF0 = 1;
  localparam int B_BER  = 2;
  localparam int B_ABC  = 3;
  localparam int B_IU0  = 4;
  localparam int B_IU1  = 5;
  localparam int B_OU   = 6;
  localparam int B_QD   = 7;
  localparam int B_EOF0 = 8;
  localparam int B_BS0  = 9;
  localparam int B_SINT = 10;
  localparam int B_RDST = 11;
  localparam int B_CMDI = 12;
  localparam int BERCH_LO = 28;
  localparam int BERCH_W  = 3;

  // descriptor command qualifiers
  localparam int CMD_EOF_BIT = 21;
  localparam int CMD_SOF_BIT = 22;

  // secondary layout offsets relative to channel number
  localparam int SOF_OFS = -1;
  localparam int EOF_OFS = 7;
  localparam int BS_OFS  = 15;

  localparam logic [REG_W-1:0] P_CLR  = 32'h0000_0fff;
  localparam logic [REG_W-1:0] P_LVL  = 32'h0000_1fff;
  localparam logic [REG_W-1:0] S_CLR  = 32'h003e_3f3f;
  localparam logic [REG_W-1:0] M0_WR  = 32'h0000_1fff;
  localparam logic [REG_W-1:0] M1_WR  = 32'h3f3f_3f3f;
  localparam logic [REG_W-1:0] BERCH_M = 32'h7000_0000;
endpackage

// File: rtl/lcd_irq_chan_qual.sv
module lcd_irq_chan_qual
  import lcd_irq_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic             sof_stb,
  input  logic             eof_stb,
  input  logic             bs_stb,
  input  logic             ber_stb,
  input  logic [REG_W-1:0] cmd,
  input  logic [REG_W-1:0] mask0,
  input  logic [REG_W-1:0] mask1,
  output logic [REG_W-1:0] set0,
  output logic [REG_W-1:0] set1,
  output logic             req,
  output logic [2:0]       cnt
);
  logic sof_ok, eof_ok;
  logic u_sof, u_eof, u_bs;

  assign sof_ok = sof_stb & cmd[CMD_SOF_BIT];
  assign eof_ok = eof_stb & cmd[CMD_EOF_BIT];

  generate
    if (CH == 0) begin : g_prim
      always_comb begin
        set0 = '0;
        set1 = '0;
        set0[B_SOF0] = sof_ok;
        set0[B_EOF0] = eof_ok;
        set0[B_BS0]  = bs_stb;
        u_sof = sof_ok & ~mask0[B_SOF0];
        u_eof = eof_ok & ~mask0[B_EOF0];
        u_bs  = bs_stb & ~mask0[B_BS0];
      end
    end else begin : g_sec
      localparam int IX_SOF = CH + SOF_OFS;
      localparam int IX_EOF = CH + EOF_OFS;
      localparam int IX_BS  = CH + BS_OFS;
      always_comb begin
        set0 = '0;
        set1 = '0;
        set1[IX_SOF] = sof_ok;
        set1[IX_EOF] = eof_ok;
        set1[IX_BS]  = bs_stb;
        u_sof = sof_ok & ~mask1[IX_SOF];
        u_eof = eof_ok & ~mask1[IX_EOF];
        u_bs  = bs_stb & ~mask1[IX_BS];
      end
    end
  endgenerate

  assign req = ber_stb | u_sof | u_eof | u_bs;
  assign cnt = 3'(ber_stb) + 3'(u_sof) + 3'(u_eof) + 3'(u_bs);
endmodule

// File: rtl/lcd_irq_id_pick.sv
module lcd_irq_id_pick #(
  parameter int NCH  = 7,
  parameter int ID_W = 32
) (
  input  logic [NCH-1:0]      req,
  input  logic [NCH-1:0]      ber,
  input  logic [NCH*ID_W-1:0] fid,
  output logic                any_req,
  output logic                any_ber,
  output logic [ID_W-1:0]     id_sel,
  output logic [2:0]          ber_ch
);
  always_comb begin
    id_sel = '0;
    ber_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) id_sel = fid[i*ID_W +: ID_W];
      if (ber[i]) ber_ch = 3'(i);
    end
  end

  assign any_req = |req;
  assign any_ber = |ber;
endmodule

// File: rtl/lcd_irq_level.sv
module lcd_irq_level
  import lcd_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] stat0,
  input  logic [REG_W-1:0] stat1,
  input  logic [REG_W-1:0] mask0,
  input  logic [REG_W-1:0] mask1,
  output logic             irq_now,
  output logic             irq
);
  assign irq_now = (|(stat0 & ~mask0 & P_LVL)) | (|(stat1 & ~mask1));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_now;
  end
endmodule

// File: rtl/lcd_irq_agg.sv
module lcd_irq_agg
  import lcd_irq_pkg::*;
#(
  parameter int NCH  = 7,
  parameter int ID_W = 32,
  parameter int AW   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NCH-1:0]      sof_stb,
  input  logic [NCH-1:0]      eof_stb,
  input  logic [NCH-1:0]      bs_stb,
  input  logic [NCH-1:0]      ber_stb,
  input  logic [NCH*32-1:0]   ch_cmd,
  input  logic [NCH*ID_W-1:0] ch_fid,
  input  logic [1:0]          iu_stb,
  input  logic                ldd_stb,
  input  logic                abc_stb,
  input  logic                ou_stb,
  input  logic                rdst_stb,
  input  logic                cmdi_stb,
  output logic                irq
);
  localparam int CNT_W = $clog2(4 * NCH + 1);

  logic             ctrl_q;
  logic [REG_W-1:0] stat0_q, stat1_q, mask0_q, mask1_q;
  logic [ID_W-1:0]  id_q;

  logic [REG_W-1:0] set0_a [NCH];
  logic [REG_W-1:0] set1_a [NCH];
  logic [2:0]       cnt_a  [NCH];
  logic [NCH-1:0]   req_v;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      lcd_irq_chan_qual #(.CH(g)) u_qual (
        .sof_stb (sof_stb[g]),
        .eof_stb (eof_stb[g]),
        .bs_stb  (bs_stb[g]),
        .ber_stb (ber_stb[g]),
        .cmd     (ch_cmd[g*32 +: 32]),
        .mask0   (mask0_q),
        .mask1   (mask1_q),
        .set0    (set0_a[g]),
        .set1    (set1_a[g]),
        .req     (req_v[g]),
        .cnt     (cnt_a[g])
      );
    end
  endgenerate

  logic             any_req, any_ber;
  logic [ID_W-1:0]  id_sel;
  logic [2:0]       ber_ch;

  lcd_irq_id_pick #(.NCH(NCH), .ID_W(ID_W)) u_pick (
    .req     (req_v),
    .ber     (ber_stb),
    .fid     (ch_fid),
    .any_req (any_req),
    .any_ber (any_ber),
    .id_sel  (id_sel),
    .ber_ch  (ber_ch)
  );

  logic irq_now;

  lcd_irq_level u_level (
    .clk     (clk),
    .rst     (rst),
    .stat0   (stat0_q),
    .stat1   (stat1_q),
    .mask0   (mask0_q),
    .mask1   (mask1_q),
    .irq_now (irq_now),
    .irq     (irq)
  );

  logic [REG_W-1:0] chs0, chs1;
  logic [CNT_W-1:0] evt_cnt;

  always_comb begin
    chs0    = '0;
    chs1    = '0;
    evt_cnt = '0;
    for (int i = 0; i < NCH; i++) begin
      chs0    = chs0 | set0_a[i];
      chs1    = chs1 | set1_a[i];
      evt_cnt = evt_cnt + CNT_W'(cnt_a[i]);
    end
  end

  logic wr_ctrl, wr_s0, wr_s1, wr_m0, wr_m1;
  assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
  assign wr_s0   = wr_en && (wr_addr == AW'(A_STAT0));
  assign wr_s1   = wr_en && (wr_addr == AW'(A_STAT1));
  assign wr_m0   = wr_en && (wr_addr == AW'(A_MASK0));
  assign wr_m1   = wr_en && (wr_addr == AW'(A_MASK1));

  logic qd_evt, sint_evt, cap;
  assign qd_evt   = wr_ctrl && ctrl_q && !wr_data[0];
  assign sint_evt = (any_req && irq_now) || (evt_cnt > CNT_W'(1));
  assign cap      = any_req && !irq_now;

  logic [REG_W-1:0] set0_all, clr0, clr1, stat0_n, stat1_n;

  always_comb begin
    set0_all = chs0;
    set0_all[B_LDD]  = chs0[B_LDD]  | ldd_stb;
    set0_all[B_ABC]  = chs0[B_ABC]  | abc_stb;
    set0_all[B_IU0]  = chs0[B_IU0]  | iu_stb[0];
    set0_all[B_IU1]  = chs0[B_IU1]  | iu_stb[1];
    set0_all[B_OU]   = chs0[B_OU]   | ou_stb;
    set0_all[B_QD]   = chs0[B_QD]   | qd_evt;
    set0_all[B_RDST] = chs0[B_RDST] | rdst_stb;
    set0_all[B_CMDI] = chs0[B_CMDI] | cmdi_stb;
    set0_all[B_BER]  = chs0[B_BER]  | any_ber;
    set0_all[B_SINT] = chs0[B_SINT] | sint_evt;

    clr0 = '0;
    if (wr_s0) begin
      clr0 = wr_data & P_CLR;
      if (wr_data[B_BER]) clr0 = clr0 | BERCH_M;
    end
    clr1 = wr_s1 ? (wr_data & S_CLR) : '0;

    stat0_n = (stat0_q & ~clr0) | set0_all;
    if (any_ber) stat0_n[BERCH_LO +: BERCH_W] = ber_ch;
    stat1_n = (stat1_q & ~clr1) | chs1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 1'b0;
      stat0_q <= '0;
      stat1_q <= '0;
      mask0_q <= '0;
      mask1_q <= '0;
      id_q    <= '0;
    end else begin
      stat0_q <= stat0_n;
      stat1_q <= stat1_n;
      if (wr_ctrl) ctrl_q  <= wr_data[0];
      if (wr_m0)   mask0_q <= wr_data & M0_WR;
      if (wr_m1)   mask1_q <= wr_data & M1_WR;
      if (cap)     id_q    <= id_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        AW'(A_CTRL):  rd_data <= {{(REG_W-1){1'b0}}, ctrl_q};
        AW'(A_STAT0): rd_data <= stat0_q;
        AW'(A_STAT1): rd_data <= stat1_q;
        AW'(A_MASK0): rd_data <= mask0_q;
        AW'(A_MASK1): rd_data <= mask1_q;
        AW'(A_ID):    rd_data <= REG_W'(id_q);
        default:      rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lcd_irq_agg_chk.sv
module lcd_irq_agg_chk
  import lcd_irq_pkg::*;
#(
  parameter int NCH  = 7,
  parameter int ID_W = 32,
  parameter int AW   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [REG_W-1:0] wr_data,
  input logic [NCH-1:0]   ber_stb,
  input logic             ldd_stb,
  input logic             ctrl_q,
  input logic [REG_W-1:0] stat0_q,
  input logic [REG_W-1:0] stat1_q,
  input logic [ID_W-1:0]  id_q,
  input logic             irq_now,
  input logic             irq
);
  // R4
  ber_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|ber_stb) |=> stat0_q[B_BER]);

  // R11
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ldd_stb |=> stat0_q[B_LDD]);

  // R7
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq_now |=> $stable(id_q));

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stat0_q == '0 && stat1_q == '0) |=> !irq);

  // R10
  quick_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(A_CTRL) && ctrl_q && !wr_data[0]) |=> stat0_q[B_QD]);
endmodule

bind lcd_irq_agg lcd_irq_agg_chk #(.NCH(NCH), .ID_W(ID_W), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .ber_stb (ber_stb),
  .ldd_stb (ldd_stb),
  .ctrl_q  (ctrl_q),
  .stat0_q (stat0_q),
  .stat1_q (stat1_q),
  .id_q    (id_q),
  .irq_now (irq_now),
  .irq     (irq)
);

// File: tb/lcd_irq_agg_test.sv
module lcd_irq_agg_test;
  localparam int NCH  = 7;
  localparam int ID_W = 32;
  localparam int AW   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [AW-1:0]     rd_addr = '0;
  logic [31:0]       rd_data;
  logic [NCH-1:0]    sof_stb = '0, eof_stb = '0, bs_stb = '0, ber_stb = '0;
  logic [NCH*32-1:0] ch_cmd = '0;
  logic [NCH*ID_W-1:0] ch_fid;
  logic [1:0]        iu_stb = '0;
  logic              ldd_stb = 1'b0, abc_stb = 1'b0, ou_stb = 1'b0;
  logic              rdst_stb = 1'b0, cmdi_stb = 1'b0;
  logic              irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lcd_irq_agg #(.NCH(NCH), .ID_W(ID_W), .AW(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sof_stb(sof_stb), .eof_stb(eof_stb),
    .bs_stb(bs_stb), .ber_stb(ber_stb), .ch_cmd(ch_cmd), .ch_fid(ch_fid),
    .iu_stb(iu_stb), .ldd_stb(ldd_stb), .abc_stb(abc_stb), .ou_stb(ou_stb),
    .rdst_stb(rdst_stb), .cmdi_stb(cmdi_stb), .irq(irq)
  );

  function automatic logic [31:0] fidv(input int ch);
    return 32'h1000_0000 * (ch + 1) + 32'h5a;
  endfunction

  initial begin
    for (int i = 0; i < NCH; i++) ch_fid[i*ID_W +: ID_W] = fidv(i);
  end

  // vector: ch[63:60] kind[59:56] (0 sof,1 eof,2 branch) cmd[55:48] (bit0 -> cmd21, bit1 -> cmd22)
  //         expected primary[47:32] expected secondary[31:0]
  localparam logic [63:0] VEC [13] = '{
    {4'd0, 4'd0, 8'h02, 16'h0002, 32'h0000_0000},
    {4'd0, 4'd0, 8'h00, 16'h0000, 32'h0000_0000},
    {4'd0, 4'd1, 8'h01, 16'h0100, 32'h0000_0000},
    {4'd0, 4'd1, 8'h02, 16'h0000, 32'h0000_0000},
    {4'd0, 4'd2, 8'h00, 16'h0200, 32'h0000_0000},
    {4'd1, 4'd0, 8'h02, 16'h0000, 32'h0000_0001},
    {4'd3, 4'd1, 8'h01, 16'h0000, 32'h0000_0400},
    {4'd6, 4'd0, 8'h02, 16'h0000, 32'h0000_0020},
    {4'd6, 4'd1, 8'h01, 16'h0000, 32'h0000_2000},
    {4'd2, 4'd2, 8'h00, 16'h0000, 32'h0002_0000},
    {4'd6, 4'd2, 8'h00, 16'h0000, 32'h0020_0000},
    {4'd4, 4'd0, 8'h03, 16'h0000, 32'h0000_0008},
    {4'd5, 4'd1, 8'h00, 16'h0000, 32'h0000_0000}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse(input int kind, input int ch);
    @(negedge clk);
    case (kind)
      0: sof_stb[ch] = 1'b1;
      1: eof_stb[ch] = 1'b1;
      2: bs_stb[ch]  = 1'b1;
      default: ber_stb[ch] = 1'b1;
    endcase
    @(negedge clk);
    sof_stb = '0; eof_stb = '0; bs_stb = '0; ber_stb = '0;
  endtask

  task automatic clear_all();
    wr(1, 32'h0000_0fff);
    wr(2, 32'hffff_ffff);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check(v, 32'h0, $sformatf("R1 reg %0d after reset", a));
    end
    check({31'b0, irq}, 32'h0, "R1 irq after reset");

    // R13 mask write widths, unused address
    wr(3, 32'hffff_ffff);
    rd(3, v); check(v, 32'h0000_1fff, "R13 mask0 readback");
    wr(4, 32'hffff_ffff);
    rd(4, v); check(v, 32'h3f3f_3f3f, "R13 mask1 readback");
    rd(7, v); check(v, 32'h0, "R13 unused address");
    wr(3, 32'h0);
    wr(4, 32'h0);

    // R2 R3 R6 vector table
    for (int i = 0; i < 13; i++) begin
      logic [63:0] e;
      int ch, kind;
      e = VEC[i];
      ch = int'(e[63:60]);
      kind = int'(e[59:56]);
      clear_all();
      ch_cmd[ch*32 +: 32] = {9'b0, e[49], e[48], 21'b0};
      pulse(kind, ch);
      rd(1, v); check(v, {16'b0, e[47:32]}, $sformatf("R2/R3 vec %0d primary", i));
      rd(2, v); check(v, e[31:0], $sformatf("R2/R3 vec %0d secondary", i));
      if (e[47:32] != 16'h0 || e[31:0] != 32'h0) begin
        rd(5, v); check(v, fidv(ch), $sformatf("R6 vec %0d id", i));
      end
    end

    for (int i = 0; i < NCH; i++) ch_cmd[i*32 +: 32] = 32'h0060_0000;

    // R5 irq timing and masking
    clear_all();
    @(negedge clk); ldd_stb = 1'b1;
    @(negedge clk); ldd_stb = 1'b0;
    check({31'b0, irq}, 32'h0, "R5 irq one cycle after status");
    @(negedge clk);
    check({31'b0, irq}, 32'h1, "R5 irq two cycles after strobe");
    wr(3, 32'h0000_0001);
    check({31'b0, irq}, 32'h1, "R5 irq right after mask write");
    @(negedge clk);
    check({31'b0, irq}, 32'h0, "R5 irq masked");
    wr(3, 32'h0);
    clear_all();

    // R6 R7 capture and secondary flag
    pulse(0, 2);
    rd(2, v); check(v, 32'h0000_0002, "R6 ch2 sof secondary");
    rd(5, v); check(v, fidv(2), "R6 first id captured");
    rd(1, v); check(v, 32'h0, "R7 no secondary flag on first");
    pulse(1, 4);
    rd(1, v); check(v, 32'h0000_0400, "R7 secondary flag while pending");
    rd(5, v); check(v, fidv(2), "R7 id held while pending");
    clear_all();
    @(negedge clk); bs_stb[3] = 1'b1; sof_stb[5] = 1'b1;
    @(negedge clk); bs_stb = '0; sof_stb = '0;
    rd(5, v); check(v, fidv(3), "R6 lowest channel id");
    rd(1, v); check(v, 32'h0000_0400, "R7 simultaneous flag");
    rd(2, v); check(v, 32'h0004_0010, "R3 simultaneous secondary bits");
    clear_all();
    wr(4, 32'h0000_0002);
    pulse(0, 2);
    rd(2, v); check(v, 32'h0000_0002, "R6 masked event recorded");
    rd(5, v); check(v, fidv(3), "R6 masked event no capture");
    check({31'b0, irq}, 32'h0, "R5 masked secondary no irq");
    wr(4, 32'h0);
    clear_all();

    // R4 R8 bus error
    pulse(3, 5);
    rd(1, v); check(v, 32'h5000_0004, "R4 bus error ch5");
    rd(5, v); check(v, fidv(5), "R4 bus error id");
    @(negedge clk); ber_stb[3] = 1'b1; ber_stb[6] = 1'b1;
    @(negedge clk); ber_stb = '0;
    rd(1, v); check(v, 32'h3000_0404, "R4 lowest channel, R7 flag");
    rd(5, v); check(v, fidv(5), "R7 id held on bus error");
    wr(1, 32'h0000_0004);
    rd(1, v); check(v, 32'h0000_0400, "R8 bus error clears channel field");
    clear_all();
    rd(1, v); check(v, 32'h0, "R8 full clear");

    // R11 clear collides with event
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h1; ldd_stb = 1'b1;
    @(negedge clk); wr_en = 1'b0; ldd_stb = 1'b0;
    rd(1, v); check(v, 32'h0000_0001, "R11 primary event wins");
    clear_all();
    pulse(0, 1);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h1; sof_stb[1] = 1'b1;
    @(negedge clk); wr_en = 1'b0; sof_stb = '0;
    rd(2, v); check(v, 32'h0000_0001, "R11 secondary event wins");
    wr(2, 32'h1);
    rd(2, v); check(v, 32'h0, "R9 secondary bit0 cleared");
    clear_all();

    // R9 uncleared branch bit of channel 1
    pulse(2, 1);
    wr(2, 32'hffff_ffff);
    rd(2, v); check(v, 32'h0001_0000, "R9 bit16 stays");
    wr(4, 32'h0001_0000);
    @(negedge clk);
    check({31'b0, irq}, 32'h0, "R5 bit16 masked");
    clear_all();

    // R10 quick disable
    wr(0, 32'h1);
    rd(1, v); check(v, 32'h0, "R10 enable write no flag");
    rd(0, v); check(v, 32'h1, "R13 ctrl readback");
    wr(0, 32'h0);
    rd(1, v); check(v, 32'h0000_0080, "R10 disable sets flag");
    clear_all();
    wr(0, 32'h0);
    rd(1, v); check(v, 32'h0, "R10 repeat disable no flag");

    // R12 R8 controller-wide strobes
    @(negedge clk);
    ldd_stb = 1'b1; abc_stb = 1'b1; iu_stb = 2'b11; ou_stb = 1'b1;
    rdst_stb = 1'b1; cmdi_stb = 1'b1;
    @(negedge clk);
    ldd_stb = 1'b0; abc_stb = 1'b0; iu_stb = 2'b00; ou_stb = 1'b0;
    rdst_stb = 1'b0; cmdi_stb = 1'b0;
    rd(1, v); check(v, 32'h0000_1879, "R12 controller-wide bits");
    wr(1, 32'h0000_0fff);
    rd(1, v); check(v, 32'h0000_1000, "R8 bit12 not clearable");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule